// File: doc/BRIEF.md
# Per-Channel Overflow Indicator

This block watches a stereo stream of 20-bit two's-complement samples and raises one active-high flag per channel whenever that channel comes close to clipping. A sample counts as near-clip when it reaches or passes either of two programmable detect levels, one positive and one negative. The flag rises combinationally in the same cycle that the offending sample is accepted. It then holds for a fixed number of sample periods (4096 by default, about 85 ms at 48 kHz) and clears itself. There is no clear input.

Samples arrive as a left/right pair on a valid/ready stream, one pair per sample period. The block never applies back-pressure while it is running: `smp_ready` is low only during power-down. While `smp_ready` is low, any presented pair is dropped. The hold timers count accepted pairs, not clock cycles, so gaps in the stream stretch the hold in time but not in samples. A detection that arrives during a hold restarts that channel's count. Power-down clears both timers and forces both flags low.

Top module: `ovf_flag_monitor`

## Requirements
- R1: After reset, with `pwr_dn` low and no accepted hit, both flags are low and `smp_ready` is high.
- R2: An accepted sample that is greater than or equal to `lvl_pos` (signed 20-bit compare) drives its channel's flag high in the same cycle.
- R3: An accepted sample that is less than or equal to `lvl_neg` (signed 20-bit compare) drives its channel's flag high in the same cycle.
- R4: An accepted sample strictly between `lvl_neg` and `lvl_pos` starts no hold. The flag stays low if no hold is running.
- R5: After the accepting edge of a hit, the flag stays high while the next 4095 pairs are accepted. It falls at the clock edge that accepts the 4096th pair after the hit, provided that pair is not itself a hit.
- R6: A hit accepted while the flag is already high restarts that channel's hold count from the full value.
- R7: A pair presented with `smp_valid` low neither starts a hold nor advances a running one.
- R8: Left and right are judged and timed independently. A hit on one channel never changes the other channel's flag.
- R9: While `pwr_dn` is high, `smp_ready` is low, both flags are low, and presented pairs are ignored. On return, both holds are found cleared.
- R10: A pair is accepted exactly when `smp_valid` and `smp_ready` are both high. `smp_ready` equals the inverse of `pwr_dn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down: clears holds, forces flags low, drops ready |
| smp_valid | input | 1 | Sample pair present |
| smp_ready | output | 1 | Pair accepted when high together with valid |
| smp_left | input | 20 | Left sample, two's complement |
| smp_right | input | 20 | Right sample, two's complement |
| lvl_pos | input | 20 | Positive detect level, signed, inclusive |
| lvl_neg | input | 20 | Negative detect level, signed, inclusive |
| ovf_left | output | 1 | Left near-clip flag, active high |
| ovf_right | output | 1 | Right near-clip flag, active high |

## Verification
A hit is due in the flag during the same cycle the pair is accepted, with no register in between. The bench therefore drives each pair on the falling clock edge and samples both flags and ready 1 ns later, before the rising edge commits the hold. The hold's end is due after the rising edge that accepts the 4096th following pair. The bench's reference model decrements its own count only after each check and only on accepted pairs, so every cycle compares against the value due in that cycle. Directed runs place pairs exactly on and one step inside each level, run a full hold end to end, retrigger mid-hold, and insert valid gaps and power-down. Seeded random traffic follows.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
  localparam int SMP_W_DEF   = 20;
  localparam int HOLD_DEF    = 4096;
  localparam int NUM_CH      = 2;
  localparam int CH_LEFT     = 0;
  localparam int CH_RIGHT    = 1;
endpackage

// File: rtl/ovf_level_cmp.sv
// Inclusive signed comparison of one sample against both detect levels.
module ovf_level_cmp #(
  parameter int SMP_W = 20
) (
  input  logic [SMP_W-1:0] smp,
  input  logic [SMP_W-1:0] lvl_pos,
  input  logic [SMP_W-1:0] lvl_neg,
  output logic             near_clip
);
  logic hit_pos;
  logic hit_neg;

  always_comb begin
    hit_pos   = $signed(smp) >= $signed(lvl_pos);
    hit_neg   = $signed(smp) <= $signed(lvl_neg);
    near_clip = hit_pos | hit_neg;
  end
endmodule

// File: rtl/ovf_hold_timer.sv
// Counts accepted samples down from HOLD after each load; active while nonzero.
module ovf_hold_timer #(
  parameter int HOLD = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic step,
  output logic active
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= FULL;
    end else if (step && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/ovf_channel.sv
// One channel: level compare, hold timer, flag merge.
module ovf_channel #(
  parameter int SMP_W = 20,
  parameter int HOLD  = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             accept,
  input  logic [SMP_W-1:0] smp,
  input  logic [SMP_W-1:0] lvl_pos,
  input  logic [SMP_W-1:0] lvl_neg,
  output logic             flag
);
  logic near_clip;
  logic hit_now;
  logic holding;

  ovf_level_cmp #(.SMP_W(SMP_W)) u_cmp (
    .smp       (smp),
    .lvl_pos   (lvl_pos),
    .lvl_neg   (lvl_neg),
    .near_clip (near_clip)
  );

  assign hit_now = accept & near_clip;

  ovf_hold_timer #(.HOLD(HOLD)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (pwr_dn),
    .load   (hit_now),
    .step   (accept),
    .active (holding)
  );

  // zero-latency detection: the accepting cycle already shows the flag
  assign flag = ~pwr_dn & (hit_now | holding);
endmodule

// File: rtl/ovf_flag_monitor.sv
module ovf_flag_monitor
  import ovf_pkg::*;
#(
  parameter int SMP_W        = SMP_W_DEF,
  parameter int HOLD_SAMPLES = HOLD_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  input  logic [SMP_W-1:0] lvl_pos,
  input  logic [SMP_W-1:0] lvl_neg,
  output logic             ovf_left,
  output logic             ovf_right
);
  logic             accept;
  logic [SMP_W-1:0] ch_smp  [NUM_CH];
  logic [NUM_CH-1:0] ch_flag;

  assign smp_ready = ~pwr_dn;
  assign accept    = smp_valid & smp_ready;

  assign ch_smp[CH_LEFT]  = smp_left;
  assign ch_smp[CH_RIGHT] = smp_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ovf_channel #(.SMP_W(SMP_W), .HOLD(HOLD_SAMPLES)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_dn  (pwr_dn),
      .accept  (accept),
      .smp     (ch_smp[c]),
      .lvl_pos (lvl_pos),
      .lvl_neg (lvl_neg),
      .flag    (ch_flag[c])
    );
  end

  assign ovf_left  = ch_flag[CH_LEFT];
  assign ovf_right = ch_flag[CH_RIGHT];
endmodule

// File: rtl/ovf_flag_monitor_checker.sv
module ovf_flag_monitor_checker #(
  parameter int SMP_W        = 20,
  parameter int HOLD_SAMPLES = 4096
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_dn,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic [SMP_W-1:0] smp_left,
  input logic [SMP_W-1:0] smp_right,
  input logic [SMP_W-1:0] lvl_pos,
  input logic [SMP_W-1:0] lvl_neg,
  input logic             ovf_left,
  input logic             ovf_right
);
  localparam int TW = $clog2(HOLD_SAMPLES + 2) + 1;

  logic acc, hit_l, hit_r;
  assign acc   = smp_valid && smp_ready;
  assign hit_l = ($signed(smp_left) >= $signed(lvl_pos)) || ($signed(smp_left) <= $signed(lvl_neg));
  assign hit_r = ($signed(smp_right) >= $signed(lvl_pos)) || ($signed(smp_right) <= $signed(lvl_neg));

  // samples accepted since the last left hit, saturating
  logic [TW-1:0] age_l;
  logic          armed_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_l   <= '0;
      armed_l <= 1'b0;
    end else if (pwr_dn) begin
      armed_l <= 1'b0;
    end else if (acc && hit_l) begin
      age_l   <= TW'(1);
      armed_l <= 1'b1;
    end else if (acc && armed_l && (age_l <= TW'(HOLD_SAMPLES))) begin
      age_l <= age_l + 1'b1;
    end
  end

  assert_hit_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ($signed(smp_left) >= $signed(lvl_pos))) |-> ovf_left);

  assert_hit_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ($signed(smp_right) <= $signed(lvl_neg))) |-> ovf_right);

  assert_hold_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_l && !pwr_dn && (age_l <= TW'(HOLD_SAMPLES))) |-> ovf_left);

  assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_l && (age_l > TW'(HOLD_SAMPLES)) && !(acc && hit_l)) |-> !ovf_left);

  assert_rise_needs_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_right) |-> acc);

  assert_pwr_dn_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (!ovf_left && !ovf_right && !smp_ready));

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn |-> smp_ready);
endmodule

bind ovf_flag_monitor ovf_flag_monitor_checker #(
  .SMP_W(SMP_W), .HOLD_SAMPLES(HOLD_SAMPLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
  .lvl_pos(lvl_pos), .lvl_neg(lvl_neg), .ovf_left(ovf_left), .ovf_right(ovf_right)
);

// File: tb/ovf_flag_monitor_bench.sv
`timescale 1ns/1ps
module ovf_flag_monitor_bench;
  localparam int W    = 20;
  localparam int HOLD = 4096;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pwr_dn = 1'b0;
  logic         smp_valid = 1'b0;
  logic         smp_ready;
  logic [W-1:0] smp_left = '0;
  logic [W-1:0] smp_right = '0;
  logic [W-1:0] lvl_pos = 20'sh40000;
  logic [W-1:0] lvl_neg = 20'hC0000;
  logic         ovf_left, ovf_right;

  int errors = 0;
  int checks = 0;
  int cnt_l = 0;
  int cnt_r = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  ovf_flag_monitor u_ovf_flag_monitor (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
    .lvl_pos(lvl_pos), .lvl_neg(lvl_neg), .ovf_left(ovf_left), .ovf_right(ovf_right)
  );

  function automatic bit near(input logic [W-1:0] s, input logic [W-1:0] p,
                              input logic [W-1:0] n);
    return ($signed(s) >= $signed(p)) || ($signed(s) <= $signed(n));
  endfunction

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  // one sample period: drive at negedge, check 1 ns later, advance model
  task automatic step(input bit v, input bit pd, input logic [W-1:0] l,
                      input logic [W-1:0] r);
    bit acc, hl, hr;
    @(negedge clk);
    smp_valid = v; pwr_dn = pd; smp_left = l; smp_right = r;
    #1;
    acc = v && !pd;
    hl  = acc && near(l, lvl_pos, lvl_neg);
    hr  = acc && near(r, lvl_pos, lvl_neg);
    chk(tag, "ready R10", int'(smp_ready), int'(!pd));
    chk(tag, "left flag", int'(ovf_left),  int'(!pd && (hl || cnt_l != 0)));
    chk(tag, "right flag R8", int'(ovf_right), int'(!pd && (hr || cnt_r != 0)));
    if (pd) begin
      cnt_l = 0; cnt_r = 0;
    end else if (acc) begin
      cnt_l = hl ? HOLD : ((cnt_l > 0) ? cnt_l - 1 : 0);
      cnt_r = hr ? HOLD : ((cnt_r > 0) ? cnt_r - 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R1";
    repeat (3) step(1'b0, 1'b0, '0, '0);

    // R2 inclusive positive level, and one step inside (R4)
    tag = "R4"; step(1'b1, 1'b0, 20'sh3FFFF, 20'hC0001);
    tag = "R2"; step(1'b1, 1'b0, 20'sh40000, 20'h00000);
    // R5 full hold on left with quiet samples; right untouched (R8)
    tag = "R5";
    for (int i = 0; i < HOLD + 4; i++) step(1'b1, 1'b0, 20'h00010, 20'h00020);

    // R3 inclusive negative level on right
    tag = "R3"; step(1'b1, 1'b0, '0, 20'hC0000);
    // R7 gaps do not advance the hold, and unaccepted hits are ignored
    tag = "R7";
    for (int i = 0; i < 2000; i++) step(1'b1, 1'b0, '0, '0);
    for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 20'h7FFFF, 20'h80000);
    // R6 retrigger mid-hold on right
    tag = "R6"; step(1'b1, 1'b0, '0, 20'h80000);
    for (int i = 0; i < HOLD + 2; i++) step(1'b1, 1'b0, '0, '0);

    // R9 power-down clears a running hold and ignores samples
    tag = "R9";
    step(1'b1, 1'b0, 20'h7FFFF, 20'h7FFFF);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, '0, '0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 20'h7FFFF, 20'h80000);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, '0, '0);

    // random traffic, narrow levels, occasional power-down
    tag = "R8";
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      lvl_pos = W'($urandom_range(20000, 200000));
      lvl_neg = W'(-$signed(32'($urandom_range(20000, 200000))));
      for (int i = 0; i < 6000; i++) begin
        logic [W-1:0] l, r;
        l = ($urandom_range(0, 99) < 2) ? W'($urandom) : W'($signed(32'($urandom_range(0, 30000))) - 15000);
        r = ($urandom_range(0, 99) < 2) ? W'($urandom) : W'($signed(32'($urandom_range(0, 30000))) - 15000);
        step($urandom_range(0, 9) != 0, $urandom_range(0, 999) == 0, l, r);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule